// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Tracker

This block watches the decoded command stream that a controller sends to a double-data-rate SDRAM. For every bank it follows the row state. When a column command carries auto precharge, it also follows the timeline that the device runs internally on its own: the data burst, then the write-recovery delay (writes only), then the precharge period. While that timeline runs the bank reports busy. Any command that the device would not accept is reported as illegal, together with the bank it addressed and its command code.

The decision is made on the clock edge that samples the command. An illegal command changes no state anywhere in the block. The report appears on registered outputs for the cycle that follows the command. A scheduler can read the per-bank busy flags to hold back commands, and a monitor can count the reports.

A second, bank-independent rule covers the shared data bus. For a configurable number of cycles after any write, a read to a different bank is refused until the write data has cleared the bus.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After reset every bank is idle: `bank_busy_o` is all zeros and `illegal_o` is low.
- R2: Command codes on `cmd_i` are NOP=0, ACT=1, RD=2, WR=3, PRE=4. An ACT to an idle bank is legal and opens it. An RD or WR to an idle bank is illegal.
- R3: An RD or WR with `a10_i` low to an open bank is legal, and the bank stays open and not busy.
- R4: A WR with `a10_i` high to an open bank makes the bank busy from the cycle after the command for BURST_LEN/2+1 data cycles, then T_WR recovery cycles, then T_RP precharge cycles. With the defaults this is 8 cycles, after which the bank is idle.
- R5: An RD with `a10_i` high to an open bank makes it busy for BURST_LEN/2 burst cycles plus T_RP cycles. With the defaults this is 5 cycles, after which the bank is idle.
- R6: Any non-NOP command to a bank that is busy is illegal. This includes a read or write that would interrupt the auto-precharge burst.
- R7: An ACT to a bank whose precharge has not yet finished is illegal. The first ACT after the busy window ends is legal.
- R8: Commands to other banks, including writes with auto precharge and precharges, stay legal while one bank runs its auto-precharge timeline.
- R9: For RD_BLOCK cycles after any legal WR (default 2), an RD to a bank other than the written one is illegal. An RD to the written bank is legal in that window, and an RD to any bank is legal after the window.
- R10: `illegal_o` is high in the cycle after an illegal command and carries that command's bank and code on `illegal_bank_o` and `illegal_cmd_o`. It drops again once a legal command or NOP follows.
- R11: A PRE to an open bank is legal and makes it busy for T_RP cycles before it is idle. An ACT to an already open bank is illegal.
- R12: An illegal command leaves all state untouched, so a bank's busy window still ends on the original cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | $clog2(NUM_BANKS) | Bank addressed by the command |
| a10_i | input | 1 | Auto-precharge flag for RD/WR |
| bank_busy_o | output | NUM_BANKS | Per-bank auto or explicit precharge in progress |
| illegal_o | output | 1 | Previous command was illegal |
| illegal_bank_o | output | $clog2(NUM_BANKS) | Bank of the illegal command |
| illegal_cmd_o | output | 3 | Code of the illegal command |

## Verification
The bench drives a command at a falling edge, and the rising edge that follows samples it. The illegal report and the first busy cycle are therefore both visible at the next falling edge, one cycle after the command. Busy windows are checked one sample per cycle from that first falling edge: the flag must be high for exactly the computed length and then low. To test whether an ACT or RD lands inside a window, the bench counts idle cycles from the sampled edge of the first command, so that the second command is sampled on the exact edge being tested.

// File: rtl/apt_pkg.sv
package apt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_ACTIVE,
    BK_BURST_AP,
    BK_WR_REC,
    BK_PRECHG
  } bank_st_e;
endpackage

// File: rtl/apt_bank.sv
module apt_bank
  import apt_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [2:0] cmd_i,
  input  logic       a10_i,
  input  logic       commit_i,
  output logic       illegal_o,
  output logic       busy_o
);
  localparam int WR_CYC = BURST_LEN / 2 + 1;
  localparam int RD_CYC = BURST_LEN / 2;
  localparam int M1     = (WR_CYC > T_WR) ? WR_CYC : T_WR;
  localparam int MAXC   = (M1 > T_RP) ? M1 : T_RP;
  localparam int CW     = $clog2(MAXC + 1);

  bank_st_e      state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_ap_q, rd_ap_d;

  always_comb begin
    illegal_o = 1'b0;
    if (sel_i && cmd_i != CMD_NOP) begin
      case (state_q)
        BK_IDLE:   illegal_o = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
        BK_ACTIVE: illegal_o = (cmd_i == CMD_ACT);
        default:   illegal_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_ap_d = rd_ap_q;
    case (state_q)
      BK_IDLE:
        if (commit_i && cmd_i == CMD_ACT) state_d = BK_ACTIVE;
      BK_ACTIVE:
        if (commit_i) begin
          if (cmd_i == CMD_PRE) begin
            state_d = BK_PRECHG;
            cnt_d   = CW'(T_RP);
          end else if (cmd_i == CMD_RD && a10_i) begin
            state_d = BK_BURST_AP;
            cnt_d   = CW'(RD_CYC);
            rd_ap_d = 1'b1;
          end else if (cmd_i == CMD_WR && a10_i) begin
            state_d = BK_BURST_AP;
            cnt_d   = CW'(WR_CYC);
            rd_ap_d = 1'b0;
          end
        end
      BK_BURST_AP:
        if (cnt_q == CW'(1)) begin
          state_d = rd_ap_q ? BK_PRECHG : BK_WR_REC;
          cnt_d   = rd_ap_q ? CW'(T_RP) : CW'(T_WR);
        end else cnt_d = cnt_q - CW'(1);
      BK_WR_REC:
        if (cnt_q == CW'(1)) begin
          state_d = BK_PRECHG;
          cnt_d   = CW'(T_RP);
        end else cnt_d = cnt_q - CW'(1);
      BK_PRECHG:
        if (cnt_q == CW'(1)) begin
          state_d = BK_IDLE;
          cnt_d   = '0;
        end else cnt_d = cnt_q - CW'(1);
      default: state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      rd_ap_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_ap_q <= rd_ap_d;
    end
  end

  assign busy_o = (state_q == BK_BURST_AP) || (state_q == BK_WR_REC) ||
                  (state_q == BK_PRECHG);

  a_r6_no_commit_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !commit_i);
  a_r5_rd_ap_loads_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && state_q == BK_ACTIVE && cmd_i == CMD_RD && a10_i)
    |=> (state_q == BK_BURST_AP && cnt_q == CW'(RD_CYC)));
  a_r4_wr_recovery_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_BURST_AP && cnt_q == CW'(1) && !rd_ap_q) |=> state_q == BK_WR_REC);
  a_r7_prechg_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_PRECHG && cnt_q == CW'(1)) |=> state_q == BK_IDLE);
endmodule

// File: rtl/apt_rd_guard.sv
module apt_rd_guard
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RD_BLOCK  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         commit_i,
  output logic                         illegal_o
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int GW = $clog2(RD_BLOCK + 1);

  logic [GW-1:0] win_q;
  logic [BW-1:0] wbank_q;

  // reads to another bank collide with write data still on the bus
  assign illegal_o = (cmd_i == CMD_RD) && (win_q != '0) && (bank_i != wbank_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      wbank_q <= '0;
    end else if (commit_i && cmd_i == CMD_WR) begin
      win_q   <= GW'(RD_BLOCK);
      wbank_q <= bank_i;
    end else if (win_q != '0) begin
      win_q <= win_q - GW'(1);
    end
  end

  a_r9_write_opens_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cmd_i == CMD_WR) |=> (win_q == GW'(RD_BLOCK) && wbank_q == $past(bank_i)));
  a_r9_no_commit_on_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !commit_i);
endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int RD_BLOCK  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         a10_i,
  output logic [NUM_BANKS-1:0]         bank_busy_o,
  output logic                         illegal_o,
  output logic [$clog2(NUM_BANKS)-1:0] illegal_bank_o,
  output logic [2:0]                   illegal_cmd_o
);
  localparam int BW = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0] bank_ill;
  logic                 guard_ill;
  logic                 any_ill;
  logic                 commit;

  assign any_ill = (|bank_ill) || guard_ill;
  assign commit  = (cmd_i != CMD_NOP) && !any_ill;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    apt_bank #(
      .BURST_LEN(BURST_LEN),
      .T_WR     (T_WR),
      .T_RP     (T_RP)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (bank_i == BW'(b)),
      .cmd_i    (cmd_i),
      .a10_i    (a10_i),
      .commit_i (commit && (bank_i == BW'(b))),
      .illegal_o(bank_ill[b]),
      .busy_o   (bank_busy_o[b])
    );
  end

  apt_rd_guard #(
    .NUM_BANKS(NUM_BANKS),
    .RD_BLOCK (RD_BLOCK)
  ) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd_i),
    .bank_i   (bank_i),
    .commit_i (commit),
    .illegal_o(guard_ill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_o      <= 1'b0;
      illegal_bank_o <= '0;
      illegal_cmd_o  <= CMD_NOP;
    end else begin
      illegal_o <= any_ill;
      if (any_ill) begin
        illegal_bank_o <= bank_i;
        illegal_cmd_o  <= cmd_i;
      end
    end
  end

  a_r10_report_matches_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (illegal_cmd_o == $past(cmd_i) && illegal_bank_o == $past(bank_i)));
  a_r10_nop_never_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP) |=> !illegal_o);
endmodule

// File: tb/sdram_ap_tracker_test.sv
module sdram_ap_tracker_test;
  localparam int NB       = 4;
  localparam int BL       = 4;
  localparam int TWR      = 2;
  localparam int TRP      = 3;
  localparam int RDB      = 2;
  localparam int WR_SPAN  = BL / 2 + 1 + TWR + TRP;
  localparam int RD_SPAN  = BL / 2 + TRP;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = NOP;
  logic [1:0]    bank = '0;
  logic          a10 = 1'b0;
  logic [NB-1:0] busy;
  logic          ill;
  logic [1:0]    ill_bank;
  logic [2:0]    ill_cmd;
  int            n_chk = 0;
  int            n_err = 0;

  always #2.5 clk = ~clk;

  sdram_ap_tracker #(
    .NUM_BANKS(NB), .BURST_LEN(BL), .T_WR(TWR), .T_RP(TRP), .RD_BLOCK(RDB)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .a10_i(a10),
    .bank_busy_o(busy), .illegal_o(ill), .illegal_bank_o(ill_bank), .illegal_cmd_o(ill_cmd)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drive at a falling edge; the next rising edge samples it
  task automatic issue(input logic [2:0] c, input int b, input logic ap);
    cmd = c; bank = 2'(b); a10 = ap;
    @(negedge clk);
    cmd = NOP; a10 = 1'b0;
  endtask

  task automatic span(input string tag, input int b, input int n);
    for (int i = 0; i < n; i++) begin
      check(tag, busy[b], 1);
      step();
    end
    check(tag, busy[b], 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 illegal", ill, 0);
  endtask

  task automatic t_open();
    issue(RD, 0, 1'b0);
    check("R2 rd idle", ill, 1);
    check("R10 bank", ill_bank, 0);
    check("R10 cmd", ill_cmd, RD);
    step();
    check("R10 drop", ill, 0);
    for (int b = 0; b < NB; b++) begin
      issue(ACT, b, 1'b0);
      check("R2 act", ill, 0);
    end
    issue(ACT, 0, 1'b0);
    check("R11 act open", ill, 1);
    issue(PRE, 3, 1'b0);
    check("R11 pre legal", ill, 0);
    span("R11 pre span", 3, TRP);
    issue(ACT, 3, 1'b0);
    check("R11 reopen", ill, 0);
  endtask

  task automatic t_plain();
    issue(WR, 2, 1'b0);
    check("R3 wr", ill, 0);
    check("R3 busy", busy[2], 0);
    repeat (RDB + 1) step();
    issue(RD, 2, 1'b0);
    check("R3 rd", ill, 0);
    check("R3 busy rd", busy[2], 0);
  endtask

  task automatic t_wr_ap();
    issue(WR, 0, 1'b1);
    check("R4 legal", ill, 0);
    span("R4 span", 0, WR_SPAN);
    issue(ACT, 0, 1'b0);
    check("R4 reopen", ill, 0);
  endtask

  task automatic t_rd_ap();
    issue(RD, 1, 1'b1);
    check("R5 legal", ill, 0);
    span("R5 span", 1, RD_SPAN);
    issue(ACT, 1, 1'b0);
    check("R5 reopen", ill, 0);
  endtask

  task automatic t_interrupt();
    issue(WR, 3, 1'b1);             // edge 0
    issue(RD, 3, 1'b0);             // edge 1
    check("R6 cas interrupt", ill, 1);
    check("R10 bank", ill_bank, 3);
    issue(PRE, 3, 1'b0);            // edge 2
    check("R6 pre busy", ill, 1);
    check("R10 cmd", ill_cmd, PRE);
    repeat (WR_SPAN - 3) step();    // after edge WR_SPAN-1
    check("R12 still busy", busy[3], 1);
    step();
    check("R12 ends on time", busy[3], 0);
    issue(ACT, 3, 1'b0);
    check("R12 reopen", ill, 0);
  endtask

  task automatic t_act_early();
    issue(RD, 0, 1'b1);             // edge 0, idle after edge RD_SPAN
    repeat (RD_SPAN - 1) step();
    issue(ACT, 0, 1'b0);            // sampled at edge RD_SPAN
    check("R7 act early", ill, 1);
    issue(ACT, 0, 1'b0);
    check("R7 act after", ill, 0);
    check("R7 open", busy[0], 0);
  endtask

  task automatic t_other();
    issue(WR, 0, 1'b1);
    issue(WR, 2, 1'b1);
    check("R8 wr ap other", ill, 0);
    issue(PRE, 1, 1'b0);
    check("R8 pre other", ill, 0);
    check("R8 busy", busy[2:0], 3'b111);
    repeat (WR_SPAN + 2) step();
    check("R8 all idle", busy, 0);
    for (int b = 0; b < 3; b++) begin
      issue(ACT, b, 1'b0);
      check("R8 reopen", ill, 0);
    end
  endtask

  task automatic t_guard();
    issue(WR, 0, 1'b0);             // edge E
    issue(RD, 1, 1'b0);             // E+1
    check("R9 rd other", ill, 1);
    check("R9 cmd", ill_cmd, RD);
    issue(RD, 0, 1'b0);             // E+2
    check("R9 rd same", ill, 0);
    issue(RD, 1, 1'b0);             // E+3
    check("R9 rd after", ill, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_open();
    t_plain();
    t_wr_ap();
    t_rd_ap();
    t_interrupt();
    t_act_early();
    t_other();
    t_guard();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule